// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed 16-bit register values, one Booth step per clock. It is the multiply unit of a small 16-bit processor with a multi-cycle control unit. The controller decodes the register-format multiply and hands over the two source registers. It raises a one-cycle start pulse and stalls while the busy flag is high. When done pulses, it writes the low half of the product into the destination register. The full 32-bit product is also presented for callers that want both halves.

Internally, a 17-bit accumulator, a 16-bit multiplier shift register and a single extra guard bit form one long shift chain. On every step, the two lowest bits of that chain choose what happens to the accumulator: add the multiplicand, subtract it, or leave it unchanged. The whole chain then shifts right arithmetically by one place. The extra accumulator bit keeps the most negative multiplicand exact.

Top module: `booth_mult`

## Requirements
- R1: While and just after the synchronous reset `rst` is high, `busy_o` and `done_o` are 0 and both product outputs read 0.
- R2: A `start_i` sampled high on a clock edge while `busy_o` is low is accepted, and `busy_o` is 1 after that edge.
- R3: After the accepting edge, exactly 16 further edges pass before completion. `busy_o` stays 1 for all of them, and `done_o` goes 1 on the 16th of them.
- R4: `done_o` is high for exactly one cycle per operation, and `busy_o` and `done_o` are never high together.
- R5: When `done_o` is high, `prod_o` equals the two's-complement product of `mcand_i` times `mplier_i`, both taken as signed values at the accepting edge.
- R6: When `done_o` is high, `prod_lo_o` equals bits 15:0 of that product.
- R7: A multiplicand or a multiplier of -32768 gives the exact product. This includes -32768 times -32768, which is 0x40000000.
- R8: A `start_i` sampled while `busy_o` is high is ignored. The operands present at that edge do not affect the result, and the completion time does not move.
- R9: The product outputs keep their last value until the next operation completes.
- R10: A `start_i` sampled in the cycle where `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (one-cycle pulse) |
| mcand_i | input | 16 | Signed multiplicand (first source register) |
| mplier_i | input | 16 | Signed multiplier (second source register) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_lo_o | output | 16 | Low half of the product, for the destination register |
| prod_o | output | 32 | Full signed product |

## Verification
The hardest case to reach from the ports is a start that arrives while an operation is running. The bench must show that such a start disturbs neither the accumulator, the loaded multiplicand nor the step counter. To get there, the driver raises start again midway through an operation, with different operands. The scoreboard still expects the first operand pair at the original completion time. The bench also chains operations with no gap by raising start in the done cycle. It runs the -32768 operand combinations, which need the guard bit of the accumulator.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } booth_act_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;

endpackage

// File: rtl/booth_step.sv
module booth_step #(
  parameter int W = 16,
  localparam int AW = W + 1
) (
  input  logic [AW-1:0] acc_i,
  input  logic [W-1:0]  mq_i,
  input  logic          guard_i,
  input  logic [AW-1:0] mcand_i,
  output logic [AW-1:0] acc_o,
  output logic [W-1:0]  mq_o,
  output logic          guard_o
);
  import booth_pkg::*;

  booth_act_e        act;
  logic [AW-1:0]     partial;

  always_comb begin
    unique case ({mq_i[0], guard_i})
      2'b01:   act = ACT_ADD;
      2'b10:   act = ACT_SUB;
      default: act = ACT_KEEP;
    endcase
  end

  always_comb begin
    unique case (act)
      ACT_ADD: partial = acc_i + mcand_i;
      ACT_SUB: partial = acc_i - mcand_i;
      default: partial = acc_i;
    endcase
  end

  // arithmetic right shift of {partial, mq, guard}
  assign acc_o   = {partial[AW-1], partial[AW-1:1]};
  assign mq_o    = {partial[0], mq_i[W-1:1]};
  assign guard_o = mq_i[0];

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int W = 16,
  localparam int STEPS = W,
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  import booth_pkg::*;

  booth_state_e  state;
  logic [CW-1:0] count;

  assign load_o = start_i && (state == ST_IDLE);
  assign step_o = (state == ST_RUN);
  assign last_o = step_o && (count == CW'(STEPS - 1));
  assign busy_o = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      count  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (load_o) begin
        state <= ST_RUN;
        count <= '0;
      end else if (last_o) begin
        state <= ST_IDLE;
        count <= '0;
      end else if (step_o) begin
        count <= count + 1'b1;
      end
    end
  end

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(STEPS - 1));                                   // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                        // R4
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));                                       // R4
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);                           // R2
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);                                  // R3
  AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && count != '0) |=> count != '0 || done_o); // R8

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
  parameter int W = 16,
  localparam int AW = W + 1,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic [PW-1:0] prod_o,
  output logic [W-1:0]  prod_lo_o
);

  logic [AW-1:0] acc_r, mcand_r, acc_n;
  logic [W-1:0]  mq_r, mq_n;
  logic          guard_r, guard_n;

  booth_step #(.W(W)) u_step (
    .acc_i   (acc_r),
    .mq_i    (mq_r),
    .guard_i (guard_r),
    .mcand_i (mcand_r),
    .acc_o   (acc_n),
    .mq_o    (mq_n),
    .guard_o (guard_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r   <= '0;
      mq_r    <= '0;
      guard_r <= 1'b0;
      mcand_r <= '0;
    end else if (load_i) begin
      acc_r   <= '0;
      mq_r    <= mplier_i;
      guard_r <= 1'b0;
      mcand_r <= {mcand_i[W-1], mcand_i};
    end else if (step_i) begin
      acc_r   <= acc_n;
      mq_r    <= mq_n;
      guard_r <= guard_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_o    <= '0;
      prod_lo_o <= '0;
    end else if (last_i) begin
      prod_o    <= {acc_n[W-1:0], mq_n};
      prod_lo_o <= mq_n;
    end
  end

  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> $stable(mcand_r));                  // R8
  AST_PROD_HELD: assert property (@(posedge clk) disable iff (rst)
    !last_i |=> $stable(prod_o));                               // R9
  AST_LO_MATCHES_FULL: assert property (@(posedge clk) disable iff (rst)
    prod_lo_o == prod_o[W-1:0]);                                // R6

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [W-1:0]  mcand_i,
  input  logic [W-1:0]  mplier_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  prod_lo_o,
  output logic [PW-1:0] prod_o
);

  logic load, step, last;

  booth_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  booth_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .step_i    (step),
    .last_i    (last),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .prod_o    (prod_o),
    .prod_lo_o (prod_lo_o)
  );

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> (busy_o || done_o));                // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy_o));                           // R3

endmodule

// File: tb/booth_mult_test.sv
module booth_mult_test;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy, done;
  logic [W-1:0]  prod_lo;
  logic [2*W-1:0] prod;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2*W-1:0] exp_q[$];
  logic [2*W-1:0] last_exp = '0;

  always #5 clk = ~clk;

  booth_mult #(.W(W)) uut (
    .clk(clk), .rst(rst), .start_i(start), .mcand_i(mcand), .mplier_i(mplier),
    .busy_o(busy), .done_o(done), .prod_lo_o(prod_lo), .prod_o(prod)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  // monitor: pops expected product on each done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected done", 64'(done), 64'd0);
      end else begin
        last_exp = exp_q.pop_front();
        check("R5 product", 64'(prod), 64'(last_exp));
        check("R6 low half", 64'(prod_lo), 64'(last_exp[W-1:0]));
      end
    end
  end

  // driver: called at a negedge; returns at the negedge where done is high
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit intrude);
    mcand = a; mplier = b; start = 1'b1;
    exp_q.push_back(ref_mul(a, b));
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = b + 16'd3;
    check("R2 busy after start", 64'(busy), 64'd1);
    for (int i = 2; i <= 16; i++) begin
      if (intrude && i == 6) begin
        mcand = 16'h1234; mplier = 16'h7777; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0)
        check("R3 busy window", {62'd0, busy, done}, 64'd2);
    end
    @(negedge clk);
    check("R3 done on 16th edge", 64'(done), 64'd1);
    check("R4 busy low with done", 64'(busy), 64'd0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 64'(busy), 64'd0);
    check("R1 done in reset", 64'(done), 64'd0);
    check("R1 product in reset", 64'(prod), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 low half after reset", 64'(prod_lo), 64'd0);

    run_op(16'd3, 16'd5, 1'b0);
    // R10: next start in the done cycle
    run_op(16'hFFF9, 16'd9, 1'b0);
    run_op(16'd32767, 16'd32767, 1'b0);
    // R7: most negative operands
    run_op(16'h8000, 16'h8000, 1'b0);
    run_op(16'h8000, 16'd32767, 1'b0);
    run_op(16'h8000, 16'd1, 1'b0);
    run_op(16'd1, 16'h8000, 1'b0);
    run_op(16'hFFFF, 16'hFFFF, 1'b0);
    run_op(16'd0, 16'h5A5A, 1'b0);
    // R8: start while busy, different operands
    run_op(16'd1234, 16'hFF00, 1'b1);
    @(negedge clk);
    check("R8 no restart after done", 64'(busy), 64'd0);

    // R9: outputs hold while idle
    repeat (5) @(negedge clk);
    check("R9 product held", 64'(prod), 64'(last_exp));
    check("R9 done stays low", 64'(done), 64'd0);

    for (int k = 0; k < 20; k++) begin
      run_op(16'($urandom), 16'($urandom), (k % 4) == 1);
      if (k % 3 == 0) repeat (2) @(negedge clk);
    end
    @(negedge clk);
    check("R5 all results consumed", 64'(exp_q.size()), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule